// File: doc/BRIEF.md
# Prescaled Auto-Reload Time Base

This block is a 16-bit up-counter that steps once every N input clocks, where N is set by a 16-bit prescaler ratio. The counter runs from zero up to a reload limit, goes back to zero on the next step, and marks that wrap with an update event. Both the ratio and the limit sit behind preload registers. A new value is written to the preload side at any time and reaches the active side only on an update event. The one exception is the limit, which can be switched to take effect immediately.

A register interface outside the block drives the control bits, the preload write ports, the counter write port and a software update strobe. The block returns the counter value, a one-cycle update-event pulse, a one-cycle flag-set pulse for the interrupt logic, the delayed counter enable, and a one-cycle request to clear the enable bit when one-shot mode ends a run.

Top module: `ar_timebase`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `cnt_value` is 0, all pulse outputs and `cnt_active` are 0, the active and preload limit are 0xFFFF, and the active and preload ratio are 0.
- R2: While `cnt_active` is 1 and the active limit is nonzero, the counter advances by one every (active ratio + 1) clocks. Any limit change made through the ports also takes effect.
- R3: When a step occurs while `cnt_value` equals the active limit, the counter becomes 0 on that edge. Unless updates are blocked, `upd_evt` is high for exactly the cycle in which `cnt_value` first shows 0.
- R4: A ratio written on `div_wr` reaches the active prescaler only on an update event.
- R5: With `lim_buffered` = 0, a limit written on `lim_wr` becomes active on the same edge. With `lim_buffered` = 1, the active limit loads from the preload only on an update event.
- R6: While `upd_block` = 1, no update event, no flag set and no shadow load occur.
- R7: `sw_update` clears the counter and the prescaler count on the next edge, even when `upd_block` = 1. It produces an update event when `upd_block` = 0.
- R8: `flag_set` pulses with every update event caused by overflow. It pulses with an update caused by `sw_update` only when `upd_src_ovf_only` = 0.
- R9: `cnt_active` equals `run_en` delayed by one clock, except during a one-shot stop.
- R10: When `single_shot` = 1 and an update event occurs, `stop_req` is high for the next cycle. `cnt_active` is 0 in that cycle and the one after, so counting halts.
- R11: While the active limit is 0, the counter does not step. It changes only through `cnt_wr` or `sw_update`.
- R12: Priority on the counter runs `sw_update`, then `cnt_wr`, then the step. A `cnt_wr` on the edge that would wrap suppresses the overflow and its update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counter enable control bit |
| upd_block | input | 1 | Blocks update events |
| upd_src_ovf_only | input | 1 | Only overflow sets the flag |
| lim_buffered | input | 1 | Limit goes through preload when 1 |
| single_shot | input | 1 | Stop after the next update event |
| sw_update | input | 1 | Software update strobe |
| div_wr | input | 1 | Write strobe for ratio preload |
| div_wdata | input | 16 | Ratio preload value |
| lim_wr | input | 1 | Write strobe for limit preload |
| lim_wdata | input | 16 | Limit preload value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cnt_value | output | 16 | Current counter value |
| upd_evt | output | 1 | Update event pulse |
| flag_set | output | 1 | Update flag set pulse |
| cnt_active | output | 1 | Effective counter enable |
| stop_req | output | 1 | Request to clear `run_en` |

## Verification
The properties assume that the register interface drops `run_en` in the cycle `stop_req` is seen, as a real control register would. The bench emulates that register and enforces the rule in its drive task. The properties also assume that the strobes are sampled only on clock edges. The bench sets every input on falling edges. Stimulus keeps the ratio below 4 and the limit below 9, so wraps, one-shot stops and collisions between writes and wraps occur many times. A limit of 0 is included so the frozen counter is also covered.

// File: rtl/ar_tb_pkg.sv
// Shared widths and reset constants for the prescaled time base.
// Assumes all parts of the block use the same counter width.
package ar_tb_pkg;
    localparam int unsigned TB_W    = 16;
    localparam logic [TB_W-1:0] LIM_RST = '1;
    localparam logic [TB_W-1:0] DIV_RST = '0;
endpackage

// File: rtl/ar_tb_preload.sv
// Preload/active register pair. Writes land in the preload side.
// The active side takes a write directly when immediate is set,
// otherwise it copies the preload on commit.
// Assumes wr and commit are single-cycle qualified strobes.
module ar_tb_preload #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         immediate,
    input  logic         commit,
    output logic [W-1:0] act_q
);
    logic [W-1:0] pre_q;

    // Capture software writes into the preload side.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= RST_VAL;
        else if (wr)
            pre_q <= wdata;
    end

    // Move a value to the active side, directly or on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= RST_VAL;
        else if (wr && immediate)
            act_q <= wdata;
        else if (commit)
            act_q <= pre_q;
    end
endmodule

// File: rtl/ar_tb_prescaler.sv
// Clock divider. Counts input clocks while enabled and gives one tick
// per (ratio + 1) clocks. A clear restarts the count at zero.
// Assumes the ratio only changes on an update edge.
module ar_tb_prescaler #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         clear,
    input  logic [W-1:0] ratio,
    output logic         tick
);
    logic [W-1:0] div_cnt;

    // A tick is due when the count has reached the ratio.
    always_comb tick = enable && (div_cnt == ratio);

    // Divider count: clear has priority, restart after every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (clear)
            div_cnt <= '0;
        else if (tick)
            div_cnt <= '0;
        else if (enable)
            div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/ar_tb_counter.sv
// Main up-counter with wrap at the limit. The priority order is
// clear, then write, then step. Reports an overflow only when a step
// actually wraps.
// Assumes tick is a one-cycle pulse from the prescaler.
module ar_tb_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] limit,
    input  logic         clear,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         ovf
);
    logic at_limit;

    // Wrap detection, masked by the higher-priority clear and write.
    always_comb begin
        at_limit = (value == limit);
        ovf      = tick && at_limit && !clear && !wr;
    end

    // Counter register with clear > write > step ordering.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (clear)
            value <= '0;
        else if (wr)
            value <= wdata;
        else if (tick)
            value <= at_limit ? '0 : value + 1'b1;
    end
endmodule

// File: rtl/ar_tb_update_ctl.sv
// Update-event control. Combines overflow and the software strobe into
// the update decision. Registers the event, flag and stop pulses, and
// produces the delayed counter enable with the one-shot stop.
// Assumes the enable bit is cleared by its owner when stop_req is seen.
module ar_tb_update_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic sw_update,
    input  logic upd_block,
    input  logic upd_src_ovf_only,
    input  logic single_shot,
    input  logic run_en,
    output logic upd_now,
    output logic upd_evt,
    output logic flag_set,
    output logic stop_req,
    output logic cnt_active
);
    logic flag_now;
    logic stop_now;

    // Decide this cycle's update, flag and one-shot stop.
    always_comb begin
        upd_now  = !upd_block && (ovf || sw_update);
        flag_now = !upd_block && (ovf || (sw_update && !upd_src_ovf_only));
        stop_now = single_shot && upd_now;
    end

    // Register the pulses so they line up with the wrapped counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_evt  <= 1'b0;
            flag_set <= 1'b0;
            stop_req <= 1'b0;
        end else begin
            upd_evt  <= upd_now;
            flag_set <= flag_now;
            stop_req <= stop_now;
        end
    end

    // Effective enable: one cycle behind run_en, held off by a stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_active <= 1'b0;
        else
            cnt_active <= run_en && !stop_now && !stop_req;
    end
endmodule

// File: rtl/ar_timebase.sv
// Prescaled auto-reload time base. Joins the two preload pairs (ratio
// and limit), the prescaler, the counter and the update control.
// Assumes the register interface supplies single-cycle write strobes.
module ar_timebase
    import ar_tb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            upd_block,
    input  logic            upd_src_ovf_only,
    input  logic            lim_buffered,
    input  logic            single_shot,
    input  logic            sw_update,
    input  logic            div_wr,
    input  logic [TB_W-1:0] div_wdata,
    input  logic            lim_wr,
    input  logic [TB_W-1:0] lim_wdata,
    input  logic            cnt_wr,
    input  logic [TB_W-1:0] cnt_wdata,
    output logic [TB_W-1:0] cnt_value,
    output logic            upd_evt,
    output logic            flag_set,
    output logic            cnt_active,
    output logic            stop_req
);
    logic [TB_W-1:0] ratio_act;
    logic [TB_W-1:0] lim_act;
    logic            lim_zero;
    logic            count_ok;
    logic            tick;
    logic            ovf;
    logic            upd_now;

    // Counting is allowed only when enabled and the limit is nonzero.
    always_comb begin
        lim_zero = (lim_act == '0);
        count_ok = cnt_active && !lim_zero;
    end

    ar_tb_preload #(.W(TB_W), .RST_VAL(DIV_RST)) u_ratio (
        .clk(clk), .rst_n(rst_n), .wr(div_wr), .wdata(div_wdata),
        .immediate(1'b0), .commit(upd_now), .act_q(ratio_act)
    );

    ar_tb_preload #(.W(TB_W), .RST_VAL(LIM_RST)) u_limit (
        .clk(clk), .rst_n(rst_n), .wr(lim_wr), .wdata(lim_wdata),
        .immediate(!lim_buffered), .commit(upd_now), .act_q(lim_act)
    );

    ar_tb_prescaler #(.W(TB_W)) u_div (
        .clk(clk), .rst_n(rst_n), .enable(count_ok), .clear(sw_update),
        .ratio(ratio_act), .tick(tick)
    );

    ar_tb_counter #(.W(TB_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .limit(lim_act),
        .clear(sw_update), .wr(cnt_wr), .wdata(cnt_wdata),
        .value(cnt_value), .ovf(ovf)
    );

    ar_tb_update_ctl u_upd (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .sw_update(sw_update),
        .upd_block(upd_block), .upd_src_ovf_only(upd_src_ovf_only),
        .single_shot(single_shot), .run_en(run_en), .upd_now(upd_now),
        .upd_evt(upd_evt), .flag_set(flag_set), .stop_req(stop_req),
        .cnt_active(cnt_active)
    );
endmodule

// File: rtl/ar_timebase_chk.sv
// Temporal checks on the time base, attached by bind.
module ar_timebase_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_en,
    input logic        upd_block,
    input logic        sw_update,
    input logic        cnt_wr,
    input logic [15:0] cnt_value,
    input logic        upd_evt,
    input logic        flag_set,
    input logic        cnt_active,
    input logic        stop_req,
    input logic        lim_zero
);
    // R3
    evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> (cnt_value == 16'd0));

    // R8
    flag_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |-> upd_evt);

    // R6
    blocked_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> ($past(upd_block) == 1'b0));

    // R9
    active_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_active |-> $past(run_en));

    // R10
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> !cnt_active);

    // R11
    zero_lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lim_zero) && !$past(sw_update) && !$past(cnt_wr))
            |-> $stable(cnt_value));
endmodule

bind ar_timebase ar_timebase_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .upd_block(upd_block),
    .sw_update(sw_update), .cnt_wr(cnt_wr), .cnt_value(cnt_value),
    .upd_evt(upd_evt), .flag_set(flag_set), .cnt_active(cnt_active),
    .stop_req(stop_req), .lim_zero(lim_zero)
);

// File: tb/tb_ar_timebase.sv
module tb_ar_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, upd_block = 1'b0, upd_src_ovf_only = 1'b0;
    logic        lim_buffered = 1'b0, single_shot = 1'b0, sw_update = 1'b0;
    logic        div_wr = 1'b0, lim_wr = 1'b0, cnt_wr = 1'b0;
    logic [15:0] div_wdata = '0, lim_wdata = '0, cnt_wdata = '0;
    logic [15:0] cnt_value;
    logic        upd_evt, flag_set, cnt_active, stop_req;

    int    n_chk = 0, n_bad = 0;
    string phase = "R1";
    bit    started = 0;

    // Reference state, built from the requirements.
    logic [15:0] m_cnt, m_pre, m_div_act, m_div_pre, m_lim_act, m_lim_pre;
    logic        m_act, m_evt, m_flag, m_stop;

    always #10 clk = ~clk;

    ar_timebase dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .upd_block(upd_block),
        .upd_src_ovf_only(upd_src_ovf_only), .lim_buffered(lim_buffered),
        .single_shot(single_shot), .sw_update(sw_update), .div_wr(div_wr),
        .div_wdata(div_wdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
        .upd_evt(upd_evt), .flag_set(flag_set), .cnt_active(cnt_active),
        .stop_req(stop_req)
    );

    // Reference step at each rising edge.
    always @(posedge clk) begin
        logic going, stp, wrap, ov, upd, sn;
        started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_div_act = 0; m_div_pre = 0;
            m_lim_act = 16'hFFFF; m_lim_pre = 16'hFFFF;
            m_act = 0; m_evt = 0; m_flag = 0; m_stop = 0;
        end else begin
            going = m_act && (m_lim_act != 0);
            stp   = going && (m_pre == m_div_act);
            wrap  = stp && (m_cnt == m_lim_act);
            ov    = wrap && !sw_update && !cnt_wr;
            upd   = !upd_block && (ov || sw_update);
            sn    = single_shot && upd;
            m_flag = !upd_block && (ov || (sw_update && !upd_src_ovf_only));
            m_act  = run_en && !sn && !m_stop;
            m_evt  = upd;
            m_stop = sn;
            if (sw_update) m_cnt = 0;
            else if (cnt_wr) m_cnt = cnt_wdata;
            else if (stp) m_cnt = wrap ? 16'd0 : m_cnt + 16'd1;
            if (sw_update || stp) m_pre = 0;
            else if (going) m_pre = m_pre + 16'd1;
            if (lim_wr && !lim_buffered) m_lim_act = lim_wdata;
            else if (upd) m_lim_act = m_lim_pre;
            if (upd) m_div_act = m_div_pre;
            if (lim_wr) m_lim_pre = lim_wdata;
            if (div_wr) m_div_pre = div_wdata;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) act=%0h exp=%0h", tag, phase, act, exp);
        end
    endtask

    // One cycle: compare away from the edge, then clear the strobes.
    task automatic cycle();
        @(negedge clk);
        if (started && rst_n) begin
            chk("R2 cnt_value", 32'(cnt_value), 32'(m_cnt));
            chk("R3 upd_evt", 32'(upd_evt), 32'(m_evt));
            chk("R8 flag_set", 32'(flag_set), 32'(m_flag));
            chk("R9 cnt_active", 32'(cnt_active), 32'(m_act));
            chk("R10 stop_req", 32'(stop_req), 32'(m_stop));
        end
        sw_update = 0; div_wr = 0; lim_wr = 0; cnt_wr = 0;
        if (stop_req) run_en = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        run(3);
        rst_n = 1;
        cycle();
        // R1 reset state
        chk("R1 cnt", 32'(cnt_value), 0);
        chk("R1 evt", 32'(upd_evt), 0);
        chk("R1 flag", 32'(flag_set), 0);
        chk("R1 active", 32'(cnt_active), 0);
        chk("R1 stop", 32'(stop_req), 0);

        // R11: zero limit freezes the counter at a written value.
        phase = "R11";
        cnt_wr = 1; cnt_wdata = 16'd5; lim_wr = 1; lim_wdata = 16'd0;
        cycle();
        run_en = 1;
        run(12);
        chk("R11 held value", 32'(cnt_value), 5);

        // R5: immediate limit, then buffered limit.
        phase = "R5";
        sw_update = 1; lim_wr = 1; lim_wdata = 16'd3;
        cycle();
        run(20);
        lim_buffered = 1; lim_wr = 1; lim_wdata = 16'd6;
        cycle();
        run(30);

        // R4: ratio change waits for an update event.
        phase = "R4";
        div_wr = 1; div_wdata = 16'd2;
        cycle();
        run(40);

        // R6 and R7: blocked strobe still clears, no event.
        phase = "R6";
        upd_block = 1; div_wr = 1; div_wdata = 16'd0;
        cycle();
        run(5);
        sw_update = 1;
        cycle();
        cycle();
        chk("R7 cleared while blocked", 32'(cnt_value), 0);
        chk("R6 no event while blocked", 32'(upd_evt), 0);
        run(30);
        upd_block = 0;

        // R8: software update without flag.
        phase = "R8";
        upd_src_ovf_only = 1; sw_update = 1;
        cycle();
        run(30);
        upd_src_ovf_only = 0;

        // R12: write and clear collisions.
        phase = "R12";
        sw_update = 1; cnt_wr = 1; cnt_wdata = 16'd4;
        cycle();
        run(3);
        cnt_wr = 1; cnt_wdata = 16'd2;
        cycle();
        run(20);

        // R10: one-shot run.
        phase = "R10";
        single_shot = 1; sw_update = 1;
        cycle();
        run(60);
        chk("R10 stopped", 32'(cnt_active), 0);
        single_shot = 0; run_en = 1;

        // R7 and others under constrained random stimulus.
        phase = "R7";
        for (int i = 0; i < 6000; i++) begin
            cycle();
            if ($urandom % 32 == 0) sw_update = 1;
            if ($urandom % 24 == 0) begin cnt_wr = 1; cnt_wdata = 16'($urandom % 10); end
            if ($urandom % 16 == 0) begin div_wr = 1; div_wdata = 16'($urandom % 4); end
            if ($urandom % 16 == 0) begin lim_wr = 1; lim_wdata = 16'($urandom % 9); end
            if ($urandom % 40 == 0) run_en = ~run_en;
            if ($urandom % 30 == 0) upd_block = ~upd_block;
            if ($urandom % 30 == 0) upd_src_ovf_only = ~upd_src_ovf_only;
            if ($urandom % 30 == 0) lim_buffered = ~lim_buffered;
            if ($urandom % 50 == 0) single_shot = ~single_shot;
            if (stop_req) run_en = 0;
        end
        cycle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule